// File: doc/BRIEF.md
# Sprite Attribute Table Copy Engine with Bus Arbitration

This block copies a full sprite attribute table of 160 bytes from a page-aligned source region into the dedicated sprite attribute memory. A one-cycle start pulse carries the source page (the high byte of the source address). The low byte of the source and the destination offset both begin at zero and advance together, one byte per transfer slot. The engine drives a source read address, takes the byte back combinationally on the same cycle, and issues a write strobe with offset and data toward the sprite memory.

While bytes remain, the block also judges every CPU access. The 64 KB address space is cut into eight 8 KB regions, and each region belongs to one internal bus. A model-select input chooses between two region-to-bus maps. A CPU address that lands on the same bus as the copy source is flagged as blocked, unless that bus is the CPU-internal one. So is any address inside the sprite memory window 0xFE00-0xFE9F. The surrounding fabric turns a blocked read into 0xFF and drops a blocked write. The copy runs at a fixed rate with no back-pressure: the source port must return data in the cycle the address is shown, and the sprite memory must accept every write strobe.

Top module: `sprite_dma`

## Requirements
- R1: After reset, `busy`, `oam_we` and `cpu_blocked` are all 0, whatever the CPU address.
- R2: A start page of 0xE0 or above is reduced by clearing bit 5 (page AND 0xDF). Pages below 0xE0 are used as given, so the source address is {effective page, offset}.
- R3: Each start produces exactly 160 write strobes. The k-th strobe (k = 0..159) has `oam_addr` = k, `src_addr` = {effective page, k} and `oam_data` equal to `src_data` in that cycle. `busy` drops in the cycle after the last strobe.
- R4: At normal speed (`fast_mode` = 0), the first strobe is in the 8th cycle after the start edge (strobe cycle index 7 when the cycle after the start edge is index 0), and later strobes follow every 4 cycles.
- R5: At double speed (`fast_mode` = 1), the first strobe is at cycle index 3 and later strobes follow every 2 cycles.
- R6: A start during an active copy discards the old schedule. The copy restarts from offset 0 on the new page, with a full 160-byte count and first-strobe timing.
- R7: With `model_new` = 0, regions map as follows: 0x8000-0x9FFF to the video bus, 0xE000-0xFFFF to the CPU-internal bus, all others to the main bus. While `busy`, a CPU address on the same bus as the source is blocked.
- R8: With `model_new` = 1, the map is the same except that 0xC000-0xDFFF forms a separate work-RAM bus. Source and CPU must then both be in that range, or both on the main bus, to conflict.
- R9: While `busy`, any CPU address from 0xFE00 to 0xFE9F is blocked, whatever the source bus. 0xFEA0 and above in that page are governed only by the bus rule.
- R10: While not `busy`, `cpu_blocked` is 0 for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse |
| start_page | input | 8 | Source page (address high byte) taken with start |
| fast_mode | input | 1 | 1 selects double-speed slot timing |
| model_new | input | 1 | 1 selects the map with a separate work-RAM bus |
| src_addr | output | 16 | Source read address, valid when oam_we is 1 |
| src_data | input | 8 | Source byte returned in the same cycle |
| oam_we | output | 1 | Write strobe to sprite memory |
| oam_addr | output | 8 | Sprite memory offset |
| oam_data | output | 8 | Byte to write |
| cpu_addr | input | 16 | Address of the current CPU access |
| cpu_blocked | output | 1 | 1 when that access must be blocked |
| busy | output | 1 | 1 while bytes remain to be copied |

## Verification
The bench targets the off-by-one points of the schedule. A design whose first-slot or gap counter was off by one cycle would show its strobes one cycle early or late at one of the two speeds. A count error would leave a 161st strobe or hold `busy` past the last byte. Restarting mid-copy checks that a stale offset or remaining count is not carried over. Random CPU addresses under both maps check the work-RAM split, which a design ignoring `model_new` would get wrong for 0xC000-0xDFFF. They also check the 0xFE9F/0xFEA0 edge and the masking of pages 0xE0-0xFF, where an unmasked page would read from the wrong region and pick the wrong bus.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [1:0] {
    BUS_CORE = 2'd0,
    BUS_MAIN = 2'd1,
    BUS_VID  = 2'd2,
    BUS_WRAM = 2'd3
  } bus_e;

  // Region index is address[15:13]
  function automatic bus_e bus_of(input logic [2:0] region, input logic model_new);
    bus_e b;
    case (region)
      3'd4:    b = BUS_VID;
      3'd6:    b = model_new ? BUS_WRAM : BUS_MAIN;
      3'd7:    b = BUS_CORE;
      default: b = BUS_MAIN;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sprite_dma_sched.sv
module sprite_dma_sched #(
  parameter int BYTES      = 160,
  parameter int FIRST_NORM = 8,
  parameter int FIRST_FAST = 4,
  parameter int GAP_NORM   = 4,
  parameter int GAP_FAST   = 2,
  localparam int CNT_W     = $clog2(BYTES + 1),
  localparam int TMR_W     = $clog2(FIRST_NORM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fast_mode,
  output logic             move,
  output logic             busy,
  output logic [7:0]       offset
);

  logic [CNT_W-1:0] remain_q;
  logic [TMR_W-1:0] timer_q;
  logic [7:0]       offset_q;

  localparam logic [TMR_W-1:0] FIRST_N = TMR_W'(FIRST_NORM - 1);
  localparam logic [TMR_W-1:0] FIRST_F = TMR_W'(FIRST_FAST - 1);
  localparam logic [TMR_W-1:0] GAP_N   = TMR_W'(GAP_NORM - 1);
  localparam logic [TMR_W-1:0] GAP_F   = TMR_W'(GAP_FAST - 1);

  assign busy   = (remain_q != '0);
  assign move   = busy && (timer_q == '0);
  assign offset = offset_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      timer_q  <= '0;
      offset_q <= '0;
    end else if (start) begin
      remain_q <= CNT_W'(BYTES);
      timer_q  <= fast_mode ? FIRST_F : FIRST_N;
      offset_q <= '0;
    end else if (busy) begin
      if (move) begin
        remain_q <= remain_q - 1'b1;
        offset_q <= offset_q + 1'b1;
        timer_q  <= fast_mode ? GAP_F : GAP_N;
      end else begin
        timer_q  <= timer_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sprite_dma_guard.sv
module sprite_dma_guard
  import sprite_dma_pkg::*;
#(
  parameter logic [15:0] WIN_LO = 16'hFE00,
  parameter logic [15:0] WIN_HI = 16'hFE9F
) (
  input  logic        busy,
  input  logic        model_new,
  input  logic [7:0]  src_page,
  input  logic [15:0] cpu_addr,
  output logic        blocked
);

  bus_e src_bus, cpu_bus;
  logic bus_hit, win_hit;

  always_comb begin
    src_bus = bus_of(src_page[7:5], model_new);
    cpu_bus = bus_of(cpu_addr[15:13], model_new);
    bus_hit = (src_bus != BUS_CORE) && (src_bus == cpu_bus);
    win_hit = (cpu_addr >= WIN_LO) && (cpu_addr <= WIN_HI);
    blocked = busy && (bus_hit || win_hit);
  end

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int BYTES      = 160,
  parameter int FIRST_NORM = 8,
  parameter int FIRST_FAST = 4,
  parameter int GAP_NORM   = 4,
  parameter int GAP_FAST   = 2,
  parameter logic [7:0] PAGE_LIMIT = 8'hE0,
  parameter logic [7:0] PAGE_MASK  = 8'hDF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  start_page,
  input  logic        fast_mode,
  input  logic        model_new,
  output logic [15:0] src_addr,
  input  logic [7:0]  src_data,
  output logic        oam_we,
  output logic [7:0]  oam_addr,
  output logic [7:0]  oam_data,
  input  logic [15:0] cpu_addr,
  output logic        cpu_blocked,
  output logic        busy
);

  logic [7:0] page_q;
  logic [7:0] offset;
  logic       move;

  always_ff @(posedge clk) begin
    if (!rst_n)
      page_q <= '0;
    else if (start)
      page_q <= (start_page >= PAGE_LIMIT) ? (start_page & PAGE_MASK) : start_page;
  end

  sprite_dma_sched #(
    .BYTES(BYTES), .FIRST_NORM(FIRST_NORM), .FIRST_FAST(FIRST_FAST),
    .GAP_NORM(GAP_NORM), .GAP_FAST(GAP_FAST)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_mode(fast_mode),
    .move(move), .busy(busy), .offset(offset)
  );

  sprite_dma_guard u_guard (
    .busy(busy), .model_new(model_new), .src_page(page_q),
    .cpu_addr(cpu_addr), .blocked(cpu_blocked)
  );

  assign src_addr = {page_q, offset};
  assign oam_we   = move;
  assign oam_addr = offset;
  assign oam_data = src_data;

endmodule

// File: rtl/sprite_dma_checker.sv
module sprite_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] src_addr,
  input logic        oam_we,
  input logic [7:0]  oam_addr,
  input logic [15:0] cpu_addr,
  input logic        cpu_blocked,
  input logic        busy
);

  assert_idle_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cpu_blocked);

  assert_strobe_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> busy);

  assert_dest_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oam_we && !start) |=> (!busy || oam_addr == $past(oam_addr) + 8'd1));

  assert_restart_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && oam_addr == 8'd0 && !oam_we));

  assert_window_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_addr >= 16'hFE00 && cpu_addr <= 16'hFE9F) |-> cpu_blocked);

  assert_page_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (src_addr[15:13] != 3'b111));

endmodule

bind sprite_dma sprite_dma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
  .oam_we(oam_we), .oam_addr(oam_addr), .cpu_addr(cpu_addr),
  .cpu_blocked(cpu_blocked), .busy(busy)
);

// File: tb/sprite_dma_tb.sv
module sprite_dma_tb;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  start_page = 0;
  logic        fast_mode = 0;
  logic        model_new = 0;
  logic [15:0] src_addr;
  logic [7:0]  src_data;
  logic        oam_we;
  logic [7:0]  oam_addr;
  logic [7:0]  oam_data;
  logic [15:0] cpu_addr = 0;
  logic        cpu_blocked;
  logic        busy;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign src_data = mem_byte(src_addr);

  sprite_dma u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .fast_mode(fast_mode), .model_new(model_new), .src_addr(src_addr),
    .src_data(src_data), .oam_we(oam_we), .oam_addr(oam_addr),
    .oam_data(oam_data), .cpu_addr(cpu_addr), .cpu_blocked(cpu_blocked),
    .busy(busy)
  );

  // 0 core, 1 main, 2 video, 3 work RAM
  function automatic int ref_bus(input logic [15:0] a, input logic nm);
    if (a[15:13] == 3'd4) return 2;
    if (a[15:13] == 3'd7) return 0;
    if (a[15:13] == 3'd6 && nm) return 3;
    return 1;
  endfunction

  function automatic logic ref_block(input logic bsy, input logic [7:0] pg,
                                     input logic [15:0] a, input logic nm);
    int sb, cb;
    sb = ref_bus({pg, 8'h00}, nm);
    cb = ref_bus(a, nm);
    return bsy && ((sb != 0 && sb == cb) || (a >= 16'hFE00 && a <= 16'hFE9F));
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] a;
    a = 16'($urandom);
    if ($urandom_range(3) == 0) a = {8'hFE, 8'($urandom)};
    return a;
  endfunction

  // stop_after < 0 runs to completion
  task automatic run_copy(input logic [7:0] page, input logic fast,
                          input logic nm, input int stop_after);
    logic [7:0] eff;
    int first, gap, wr, n;
    logic exp_we;
    eff   = (page >= 8'hE0) ? (page & 8'hDF) : page;
    first = fast ? 4 : 8;
    gap   = fast ? 2 : 4;
    @(negedge clk);
    start = 1; start_page = page; fast_mode = fast; model_new = nm;
    @(negedge clk);
    start = 0; start_page = 8'($urandom);
    wr = 0; n = 0;
    while (wr < 160 && (stop_after < 0 || n < stop_after)) begin
      cpu_addr = pick_addr();
      #1;
      check(cpu_blocked == ref_block(1'b1, eff, cpu_addr, nm),
            nm ? "R8 blocking" : "R7 blocking", cpu_blocked,
            ref_block(1'b1, eff, cpu_addr, nm));
      if (cpu_addr[15:8] == 8'hFE && cpu_addr[7:0] < 8'hA0)
        check(cpu_blocked == 1'b1, "R9 window", cpu_blocked, 1);
      check(busy == 1'b1, "R3 busy", busy, 1);
      exp_we = (n == first - 1 + gap * wr);
      check(oam_we == exp_we, fast ? "R5 slot timing" : "R4 slot timing", oam_we, exp_we);
      if (oam_we && exp_we) begin
        check(oam_addr == 8'(wr), "R3 dest offset", oam_addr, wr);
        check(src_addr == {eff, 8'(wr)}, "R2 source addr", src_addr, {eff, 8'(wr)});
        check(oam_data == mem_byte({eff, 8'(wr)}), "R3 data", oam_data,
              mem_byte({eff, 8'(wr)}));
      end
      if (oam_we) wr++;
      n++;
      @(negedge clk);
    end
    if (stop_after < 0) begin
      check(wr == 160, "R3 byte count", wr, 160);
      cpu_addr = 16'hFE10;
      #1;
      check(busy == 1'b0, "R3 busy drop", busy, 0);
      check(cpu_blocked == 1'b0, "R10 idle", cpu_blocked, 0);
      check(oam_we == 1'b0, "R3 no extra strobe", oam_we, 0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    cpu_addr = 16'hFE00;
    repeat (3) @(negedge clk);
    #1;
    check(busy == 0, "R1 busy", busy, 0);
    check(oam_we == 0, "R1 strobe", oam_we, 0);
    check(cpu_blocked == 0, "R1 blocked", cpu_blocked, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      cpu_addr = pick_addr();
      #1;
      check(cpu_blocked == 0, "R10 idle", cpu_blocked, 0);
      @(negedge clk);
    end
    run_copy(8'h12, 1'b0, 1'b0, -1);
    run_copy(8'hC3, 1'b0, 1'b0, -1);
    run_copy(8'hC3, 1'b1, 1'b1, -1);
    run_copy(8'hFE, 1'b0, 1'b1, -1);
    run_copy(8'hE5, 1'b1, 1'b0, -1);
    run_copy(8'h85, 1'b0, 1'b1, -1);
    // R6: restart mid-copy
    run_copy(8'h40, 1'b0, 1'b0, 30);
    run_copy(8'h81, 1'b1, 1'b1, -1);
    run_copy(8'hD0, 1'b1, 1'b1, 3);
    run_copy(8'h20, 1'b0, 1'b1, -1);
    for (int r = 0; r < 4; r++)
      run_copy(8'($urandom), 1'($urandom), 1'($urandom), -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule